// File: doc/BRIEF.md
# GPIO Interrupt Cascade Controller

This block turns twelve asynchronous, level-sensitive general-purpose inputs into interrupt requests. Each input passes through a two-flop synchronizer and a small per-pin state machine. The state machine accepts a level only after it has been seen active on several consecutive clock samples, so short glitches are rejected. An accepted level sets a sticky status bit in a 32-bit status-and-enable register. The bit is set whether or not that pin is enabled, and software clears it by writing a one.

Pending bits that are also enabled are ORed into a single summary bit (bit 12) of a top-level status register. That summary, gated by bit 12 of a top-level enable register, drives a registered, active-high interrupt pin. Software reaches all three registers through a simple synchronous bus made of address, write data, write strobe and combinational read data.

Per-pin qualifier states: `Q_IDLE` (input inactive, counter clear), `Q_COUNT` (input active, counting consecutive samples) and `Q_ACTIVE` (input accepted, request asserted). Transitions: `Q_IDLE -> Q_COUNT` on the first active sample; `Q_COUNT -> Q_COUNT` while active and not yet at the limit; `Q_COUNT -> Q_ACTIVE` on the FILT_CNT-th consecutive active sample; `Q_COUNT -> Q_IDLE` and `Q_ACTIVE -> Q_IDLE` on any inactive sample; `Q_ACTIVE -> Q_ACTIVE` while the input stays active.

Top module: `gpio_irq_cascade`

## Requirements
- R1: After reset, the pin register (byte address 0x1E8), the summary register (0x1F0) and the top enable register (0x1F4) all read 0, and `irq_out` is 0.
- R2: A pin held high across 5 consecutive rising clock edges sets its status bit n (bit n of 0x1E8, n = 0..11).
- R3: A pin held high across only 4 consecutive rising edges leaves its status bit clear.
- R4: A status bit is set by a qualified input even when its enable bit is 0.
- R5: Writing 0x1E8 clears each status bit whose write-data bit (11:0) is 1 and leaves status bits written with 0 unchanged.
- R6: Bits 27:16 of 0x1E8 are read/write enables, with bit 16+n enabling pin n, and they change only on a write to 0x1E8.
- R7: Bits 31:28 and 15:12 of 0x1E8 always read 0, whatever is written to them.
- R8: Bit 12 of 0x1E8 + 8 (0x1F0) reads as the OR over n of (status n AND enable n); all other bits read 0, and writes to 0x1F0 have no effect.
- R9: `irq_out` equals, one clock later, the AND of the summary bit and bit 12 of 0x1F4.
- R10: When a clear write and a qualified level hit the same bit in the same cycle, the bit stays set, so a level still held high re-sets the bit straight after the clear.
- R11: In 0x1F4 only bit 12 can be written; all its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NPIN (12) | Asynchronous level-sensitive interrupt inputs |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Registered active-high interrupt request |

## Verification
On every cycle the assertions check the interrupt pin against the summary and the top enable from the cycle before. They also check that a status bit rises only after a qualified request, that a clear write empties every written bit it does not collide with, that the enables stay stable unless written, and that reserved read bits are zero. The exact filter boundary, where 5 edges are accepted and 4 are not, can only be shown by the bench's scenarios. The same holds for the re-set of a held level after a clear, the rejection of writes to the summary register, and the full read-back values.

// File: rtl/gic_pkg.sv
package gic_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        Q_IDLE   = 2'd0,
        Q_COUNT  = 2'd1,
        Q_ACTIVE = 2'd2
    } qual_state_e;

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gic_qualifier.sv
module gic_qualifier
    import gic_pkg::*;
#(
    parameter int FILT_CNT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic qual_o
);

    localparam int CW = $clog2(FILT_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CNT - 1);

    qual_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            Q_IDLE: begin
                cnt_d = '0;
                if (level_i) begin
                    if (FILT_CNT <= 1) begin
                        state_d = Q_ACTIVE;
                    end else begin
                        state_d = Q_COUNT;
                        cnt_d   = CW'(1);
                    end
                end
            end
            Q_COUNT: begin
                if (!level_i) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = Q_ACTIVE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            Q_ACTIVE: begin
                cnt_d = '0;
                if (!level_i) begin
                    state_d = Q_IDLE;
                end
            end
            default: begin
                state_d = Q_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            Q_ACTIVE: qual_o = 1'b1;
            default:  qual_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/gic_regs.sv
module gic_regs
    import gic_pkg::*;
#(
    parameter int NPIN    = 12,
    parameter int EN_LSB  = 16,
    parameter int SUM_BIT = 12,
    parameter int ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] ADDR_PIN   = 12'h1E8,
    parameter logic [ADDR_W-1:0] ADDR_SUM   = 12'h1F0,
    parameter logic [ADDR_W-1:0] ADDR_TOPEN = 12'h1F4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   qual_i,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPIN-1:0]   sts_o,
    output logic [NPIN-1:0]   en_o,
    output logic              topen_o,
    output logic              sum_o
);

    localparam int EN_MSB = EN_LSB + NPIN - 1;

    logic [NPIN-1:0] sts_q, en_q, clr_mask;
    logic            topen_q;
    logic            pin_wr, topen_wr;

    assign pin_wr   = bus_we && (bus_addr == ADDR_PIN);
    assign topen_wr = bus_we && (bus_addr == ADDR_TOPEN);
    assign clr_mask = pin_wr ? bus_wdata[NPIN-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q   <= '0;
            en_q    <= '0;
            topen_q <= 1'b0;
        end else begin
            // a qualified level overrides a clear in the same cycle
            sts_q <= (sts_q & ~clr_mask) | qual_i;
            if (pin_wr) begin
                en_q <= bus_wdata[EN_MSB:EN_LSB];
            end
            if (topen_wr) begin
                topen_q <= bus_wdata[SUM_BIT];
            end
        end
    end

    assign sum_o = |(sts_q & en_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_PIN) begin
            bus_rdata[NPIN-1:0]      = sts_q;
            bus_rdata[EN_MSB:EN_LSB] = en_q;
        end else if (bus_addr == ADDR_SUM) begin
            bus_rdata[SUM_BIT] = sum_o;
        end else if (bus_addr == ADDR_TOPEN) begin
            bus_rdata[SUM_BIT] = topen_q;
        end
    end

    assign sts_o   = sts_q;
    assign en_o    = en_q;
    assign topen_o = topen_q;

endmodule

// File: rtl/gpio_irq_cascade.sv
module gpio_irq_cascade
    import gic_pkg::*;
#(
    parameter int NPIN        = 12,
    parameter int FILT_CNT    = 5,
    parameter int SYNC_STAGES = 2,
    parameter int EN_LSB      = 16,
    parameter int SUM_BIT     = 12,
    parameter int ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] ADDR_PIN   = 12'h1E8,
    parameter logic [ADDR_W-1:0] ADDR_SUM   = 12'h1F0,
    parameter logic [ADDR_W-1:0] ADDR_TOPEN = 12'h1F4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   gpio_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);

    logic [NPIN-1:0] sync_lvl;
    logic [NPIN-1:0] qual;
    logic [NPIN-1:0] sts_q, en_q;
    logic            topen_q, sum;
    logic            irq_q;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        gic_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (gpio_in[p]),
            .sync_o  (sync_lvl[p])
        );
        gic_qualifier #(.FILT_CNT(FILT_CNT)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (sync_lvl[p]),
            .qual_o  (qual[p])
        );
    end

    gic_regs #(
        .NPIN       (NPIN),
        .EN_LSB     (EN_LSB),
        .SUM_BIT    (SUM_BIT),
        .ADDR_W     (ADDR_W),
        .ADDR_PIN   (ADDR_PIN),
        .ADDR_SUM   (ADDR_SUM),
        .ADDR_TOPEN (ADDR_TOPEN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .qual_i    (qual),
        .bus_rdata (bus_rdata),
        .sts_o     (sts_q),
        .en_o      (en_q),
        .topen_o   (topen_q),
        .sum_o     (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= sum & topen_q;
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/gic_checker.sv
module gic_checker #(
    parameter int NPIN    = 12,
    parameter int EN_LSB  = 16,
    parameter int SUM_BIT = 12,
    parameter int ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] ADDR_PIN   = 12'h1E8,
    parameter logic [ADDR_W-1:0] ADDR_TOPEN = 12'h1F4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              irq_out,
    input logic [NPIN-1:0]   qual,
    input logic [NPIN-1:0]   sts_q,
    input logic [NPIN-1:0]   en_q,
    input logic              topen_q
);

    localparam logic [31:0] STS_MASK = 32'((64'd1 << NPIN) - 64'd1);
    localparam logic [31:0] EN_MASK  = STS_MASK << EN_LSB;
    localparam logic [31:0] RSV_MASK = ~(STS_MASK | EN_MASK);
    localparam logic [31:0] SUM_MASK = 32'd1 << SUM_BIT;

    a_r2_qual_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|qual) |=> ((sts_q & $past(qual)) == $past(qual)));

    a_r3_no_unqualified_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(qual)) == '0));

    a_r5_clear_empties_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_PIN)
        |=> ((sts_q & $past(bus_wdata[NPIN-1:0]) & ~$past(qual)) == '0));

    a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_PIN) |=> $stable(en_q));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_PIN) |-> ((bus_rdata & RSV_MASK) == '0));

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past((|(sts_q & en_q)) && topen_q)));

    a_r11_topen_only_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_TOPEN) |-> ((bus_rdata & ~SUM_MASK) == '0));

endmodule

bind gpio_irq_cascade gic_checker #(
    .NPIN       (NPIN),
    .EN_LSB     (EN_LSB),
    .SUM_BIT    (SUM_BIT),
    .ADDR_W     (ADDR_W),
    .ADDR_PIN   (ADDR_PIN),
    .ADDR_TOPEN (ADDR_TOPEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .qual      (qual),
    .sts_q     (sts_q),
    .en_q      (en_q),
    .topen_q   (topen_q)
);

// File: tb/sim_gpio_irq_cascade.sv
`timescale 1ns/100ps
module sim_gpio_irq_cascade;

    localparam logic [11:0] A_PIN   = 12'h1E8;
    localparam logic [11:0] A_SUM   = 12'h1F0;
    localparam logic [11:0] A_TOPEN = 12'h1F4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] gpio_in = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_cascade u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpio_in   (gpio_in),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    // hold pin p high across exactly n rising edges
    task automatic pulse(input int p, input int n);
        @(negedge clk);
        gpio_in[p] = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        gpio_in[p] = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_PIN, v);   check("R1 pin reg", v, 32'h0);
        rd(A_SUM, v);   check("R1 summary reg", v, 32'h0);
        rd(A_TOPEN, v); check("R1 top enable reg", v, 32'h0);
        check("R1 irq", {31'd0, irq_out}, 32'h0);
    endtask

    task automatic t_qualify_disabled();
        logic [31:0] v;
        pulse(3, 5); settle();
        rd(A_PIN, v); check("R2 R4 five-edge pulse sets bit 3", v, 32'h0000_0008);
        check("R4 irq stays low", {31'd0, irq_out}, 32'h0);
        wr(A_PIN, 32'h0000_0008);
        rd(A_PIN, v); check("R5 clear bit 3", v, 32'h0);
    endtask

    task automatic t_reject_short();
        logic [31:0] v;
        pulse(7, 4); settle();
        rd(A_PIN, v); check("R3 four-edge pulse rejected", v, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(1, 6); pulse(9, 8); settle();
        rd(A_PIN, v); check("R2 two pins latched", v, 32'h0000_0202);
        wr(A_PIN, 32'h0);
        rd(A_PIN, v); check("R5 zero write keeps status", v, 32'h0000_0202);
        wr(A_PIN, 32'h0000_0002);
        rd(A_PIN, v); check("R5 clear only bit 1", v, 32'h0000_0200);
        wr(A_PIN, 32'h0000_0200);
        rd(A_PIN, v); check("R5 clear bit 9", v, 32'h0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] v;
        wr(A_PIN, 32'h0ABC_0000);
        rd(A_PIN, v); check("R6 enable readback", v, 32'h0ABC_0000);
        repeat (3) @(posedge clk); #1;
        rd(A_PIN, v); check("R6 enable holds", v, 32'h0ABC_0000);
        wr(A_PIN, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(A_PIN, 32'hFFFF_FFFF);
        rd(A_PIN, v); check("R7 reserved bits read zero", v, 32'h0FFF_0000);
        wr(A_PIN, 32'hF000_F000);
        rd(A_PIN, v); check("R7 reserved write no effect", v, 32'h0);
    endtask

    task automatic t_cascade();
        logic [31:0] v;
        wr(A_PIN, 32'h0020_0000);
        pulse(5, 5); settle();
        rd(A_SUM, v); check("R8 summary set", v, 32'h0000_1000);
        check("R9 irq gated by top enable", {31'd0, irq_out}, 32'h0);
        wr(A_TOPEN, 32'hFFFF_FFFF);
        rd(A_TOPEN, v); check("R11 only bit 12 writable", v, 32'h0000_1000);
        check("R9 irq not yet high", {31'd0, irq_out}, 32'h0);
        @(posedge clk); #1;
        check("R9 irq one cycle later", {31'd0, irq_out}, 32'h1);
        wr(A_SUM, 32'h0);
        rd(A_SUM, v); check("R8 summary write ignored", v, 32'h0000_1000);
        wr(A_PIN, 32'h0);
        check("R9 irq still high at disable", {31'd0, irq_out}, 32'h1);
        rd(A_SUM, v); check("R8 disabled pending gives zero", v, 32'h0);
        rd(A_PIN, v); check("R4 status kept while disabled", v, 32'h0000_0020);
        @(posedge clk); #1;
        check("R9 irq drops one cycle later", {31'd0, irq_out}, 32'h0);
        wr(A_PIN, 32'h0000_0020);
        wr(A_TOPEN, 32'h0);
        rd(A_TOPEN, v); check("R11 top enable cleared", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk); gpio_in[2] = 1'b1;
        settle();
        wr(A_PIN, 32'h0000_0004);
        rd(A_PIN, v); check("R10 held level survives clear", v, 32'h0000_0004);
        @(negedge clk); gpio_in[2] = 1'b0;
        settle();
        wr(A_PIN, 32'h0000_0004);
        rd(A_PIN, v); check("R10 clear after release", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_qualify_disabled();
        t_reject_short();
        t_w1c();
        t_enable_rw();
        t_reserved();
        t_cascade();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule